// File: doc/BRIEF.md
# Interrupt Distributor Target and Priority Register File

This block is the byte-wide register file of a multi-processor interrupt distributor. For every implemented interrupt it holds a routing mask and a priority byte. The routing mask says which processors the interrupt may be sent to. The lowest 32 interrupts are private to each processor, so each processor has its own copy of their priority bytes. The bus carries the byte offset, write data, the number of the processor making the access, and separate read and write strobes. The block answers with registered read data and an error flag for an access to an interrupt that is not implemented.

The routing mask behaves differently from plain storage. Three private interrupts (29, 30 and 31) always read back the mask bit of the processor that asks. Writes to private routing entries are replaced by fixed values. In a single-processor build the routing window reads as zero and ignores writes. The exception is a build with the legacy-revision parameter set, which keeps the multi-processor rules. The processor count (1 to 8), the number of implemented interrupts (33 to 1020) and the legacy flag are parameters.

Top module: `irq_dist_regs`

## Requirements
- R1: Offsets 0x400–0x7FF form the priority window and offsets 0x800–0xBFF form the routing window. In each window the interrupt number is the offset minus the window base, one byte per interrupt. Any other offset reads as 0x00, never flags an error and changes no state.
- R2: Read data and the error flag are registered and appear in the cycle after the strobe. Read data is 0x00 in any cycle that does not follow a read strobe. The error flag is high only in the cycle after the offending read or write.
- R3: A routing write in a multi-processor (or legacy) build stores 0 for interrupts 0–28 and the all-processors mask (low NUM_CPU bits set) for interrupts 29–31. For interrupts 32 and up it stores the write byte ANDed with that mask. A routing read returns the stored value with the bits above NUM_CPU at zero.
- R4: A routing read of interrupt 29, 30 or 31 returns only the bit of the accessing processor (1 << cpu_id), whatever was written.
- R5: A routing or priority access whose interrupt number is at or above NUM_IRQ raises the error flag, reads 0x00 and stores nothing.
- R6: With NUM_CPU = 1 and the legacy flag clear, routing reads return 0x00 and routing writes are ignored. No error is raised, even beyond NUM_IRQ.
- R7: With NUM_CPU = 1 and the legacy flag set, the routing window follows R3–R5, and every routing entry holds 0x01 out of reset.
- R8: Priority bytes of interrupts 0–31 are kept separately for each processor and are addressed by cpu_id. Priority bytes of interrupts 32 and up are one shared copy. Priority bytes store all 8 bits.
- R9: Reset clears every priority byte to 0x00. In a multi-processor build reset clears every routing entry to 0. In a single-processor build reset sets every routing entry to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write byte |
| cpu_id | input | max(1, clog2(NUM_CPU)) | Number of the accessing processor |
| rdata | output | 8 | Registered read byte |
| err | output | 1 | Registered bad-register pulse |

## Verification
Every result of this block is due exactly one clock after its strobe. This holds for the read byte of a read, the error pulse of a read or write, and a stored value, which becomes visible to a read issued the next cycle. The bench therefore drives each access for one cycle from a falling edge and compares rdata and err on the following falling edge. A write is checked by a separate read, which yields its byte one further cycle later. Three instances cover the multi-processor, plain single-processor and legacy single-processor builds. Each has its own strobes, so stimulus aimed at one leaves the others untouched.

// File: rtl/dist_pkg.sv
package dist_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_PRIO = 2'd1,
    WIN_TGT  = 2'd2
  } win_e;

  localparam int unsigned FIXED_TGT_FIRST = 29;
  localparam int unsigned PRIVATE_COUNT   = 32;

  function automatic win_e window_of(input logic [11:0] a);
    case (a[11:10])
      2'b01:   return WIN_PRIO;
      2'b10:   return WIN_TGT;
      default: return WIN_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [11:0] addr,
  output win_e        win,
  output logic [9:0]  irq,
  output logic        bad
);
  localparam logic [9:0] IRQ_LIM = 10'(NUM_IRQ);

  always_comb begin
    win = window_of(addr);
    irq = addr[9:0];
    bad = (win != WIN_NONE) && (irq >= IRQ_LIM);
  end
endmodule

// File: rtl/dist_target_bank.sv
module dist_target_bank
  import dist_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [9:0]         irq,
  input  logic [NUM_CPU-1:0] wbits,
  input  logic [CPU_W-1:0]   cpu_id,
  output logic [7:0]         rd_byte
);
  localparam logic [NUM_CPU-1:0] ALL_MASK  = '1;
  localparam logic [NUM_CPU-1:0] RST_VALUE = (NUM_CPU == 1) ? ALL_MASK : '0;
  localparam logic [9:0] FIX_LO = 10'(FIXED_TGT_FIRST);
  localparam logic [9:0] PRIV   = 10'(PRIVATE_COUNT);

  logic [NUM_CPU-1:0] tgt_q [NUM_IRQ];
  logic [NUM_CPU-1:0] tgt_d;
  logic [NUM_CPU-1:0] own_mask;
  logic [NUM_CPU-1:0] sel;
  logic               fixed_rd;

  always_comb begin
    if (irq < FIX_LO)     tgt_d = '0;
    else if (irq < PRIV)  tgt_d = ALL_MASK;
    else                  tgt_d = wbits & ALL_MASK;
  end

  always_comb begin
    for (int k = 0; k < NUM_CPU; k++) own_mask[k] = (cpu_id == CPU_W'(k));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq == 10'(i)) sel = tgt_q[i];
    end
  end

  assign fixed_rd = (irq >= FIX_LO) && (irq < PRIV);
  assign rd_byte  = fixed_rd ? 8'(own_mask) : 8'(sel);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_entry
    logic hit;
    assign hit = we && (irq == 10'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tgt_q[g] <= RST_VALUE;
      else if (hit) tgt_q[g] <= tgt_d;
    end
  end
endmodule

// File: rtl/dist_prio_bank.sv
module dist_prio_bank
  import dist_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [9:0]       irq,
  input  logic [7:0]       wdata,
  input  logic [CPU_W-1:0] cpu_id,
  output logic [7:0]       rd_byte
);
  localparam int unsigned BANKED = NUM_CPU * PRIVATE_COUNT;
  localparam int unsigned SHARED = NUM_IRQ - PRIVATE_COUNT;
  localparam int unsigned BI_W   = CPU_W + 5;
  localparam logic [9:0]  PRIV   = 10'(PRIVATE_COUNT);

  logic [7:0]      banked_q [BANKED];
  logic [7:0]      shared_q [SHARED];
  logic            is_priv;
  logic [BI_W-1:0] bidx;
  logic [9:0]      sidx;
  logic [7:0]      bsel, ssel;

  assign is_priv = irq < PRIV;
  assign bidx    = {cpu_id, irq[4:0]};
  assign sidx    = irq - PRIV;

  always_comb begin
    bsel = '0;
    for (int j = 0; j < BANKED; j++) if (bidx == BI_W'(j)) bsel = banked_q[j];
    ssel = '0;
    for (int k = 0; k < SHARED; k++) if (sidx == 10'(k)) ssel = shared_q[k];
  end

  assign rd_byte = is_priv ? bsel : ssel;

  for (genvar g = 0; g < BANKED; g++) begin : g_banked
    logic hit;
    assign hit = we && is_priv && (bidx == BI_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   banked_q[g] <= '0;
      else if (hit) banked_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < SHARED; g++) begin : g_shared
    logic hit;
    assign hit = we && !is_priv && (sidx == 10'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shared_q[g] <= '0;
      else if (hit) shared_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import dist_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_IRQ    = 64,
  parameter bit          LEGACY_REV = 1'b0,
  localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [11:0]      addr,
  input  logic [7:0]       wdata,
  input  logic [CPU_W-1:0] cpu_id,
  output logic [7:0]       rdata,
  output logic             err
);
  localparam bit TGT_LIVE = (NUM_CPU != 1) || LEGACY_REV;

  win_e       win;
  logic [9:0] irq;
  logic       bad, raz, tgt_we, prio_we;
  logic [7:0] tgt_byte, prio_byte;
  logic [7:0] rdata_d, rdata_q;
  logic       err_d, err_q;

  dist_addr_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(addr), .win(win), .irq(irq), .bad(bad)
  );

  assign raz     = !TGT_LIVE && (win == WIN_TGT);
  assign tgt_we  = wr_en && (win == WIN_TGT) && !bad && TGT_LIVE;
  assign prio_we = wr_en && (win == WIN_PRIO) && !bad;

  dist_target_bank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_tgt (
    .clk(clk), .rst_n(rst_n), .we(tgt_we), .irq(irq),
    .wbits(wdata[NUM_CPU-1:0]), .cpu_id(cpu_id), .rd_byte(tgt_byte)
  );

  dist_prio_bank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(prio_we), .irq(irq),
    .wdata(wdata), .cpu_id(cpu_id), .rd_byte(prio_byte)
  );

  always_comb begin
    rdata_d = '0;
    if (rd_en && !bad && !raz) begin
      case (win)
        WIN_TGT:  rdata_d = tgt_byte;
        WIN_PRIO: rdata_d = prio_byte;
        default:  rdata_d = '0;
      endcase
    end
    err_d = (rd_en || wr_en) && bad && !raz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_IRQ    = 64,
  parameter bit          LEGACY_REV = 1'b0,
  localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic [11:0]      addr,
  input logic [CPU_W-1:0] cpu_id,
  input logic [7:0]       rdata,
  input logic             err
);
  localparam bit         LIVE = (NUM_CPU != 1) || LEGACY_REV;
  localparam logic [7:0] ALL8 = 8'((9'd1 << NUM_CPU) - 9'd1);

  logic       past_ok;
  logic       in_win, tgt_win, beyond;
  logic [7:0] own8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign in_win  = (addr[11:10] == 2'b01) || (addr[11:10] == 2'b10);
  assign tgt_win = addr[11:10] == 2'b10;
  assign beyond  = addr[9:0] >= 10'(NUM_IRQ);
  assign own8    = 8'h01 << cpu_id;

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && err |-> $past(rd_en || wr_en));  // R2
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(rd_en) |-> rdata == 8'h00);  // R2
  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && in_win && beyond && (LIVE || !tgt_win) |=> err);  // R5
  AST_BAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && in_win && beyond |=> rdata == 8'h00);  // R5
  AST_RAZ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !LIVE && rd_en && tgt_win |=> rdata == 8'h00 && !err);  // R6
  AST_FIXED_OWN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    LIVE && rd_en && tgt_win && addr[9:0] >= 10'd29 && addr[9:0] <= 10'd31
    |=> rdata == $past(own8));  // R4
  AST_TGT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && tgt_win |=> (rdata & ~ALL8) == 8'h00);  // R3
endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .LEGACY_REV(LEGACY_REV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .cpu_id(cpu_id), .rdata(rdata), .err(err)
);

// File: tb/sim_irq_dist_regs.sv
`timescale 1ns/1ps
module sim_irq_dist_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [1:0]  cpu = '0;
  logic        rd0 = 0, wr0 = 0, rd1 = 0, wr1 = 0, rd2 = 0, wr2 = 0;
  logic [7:0]  rdata0, rdata1, rdata2;
  logic        err0, err1, err2;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irq_dist_regs #(.NUM_CPU(4), .NUM_IRQ(64), .LEGACY_REV(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd0), .wr_en(wr0), .addr(addr),
    .wdata(wdata), .cpu_id(cpu), .rdata(rdata0), .err(err0));
  irq_dist_regs #(.NUM_CPU(1), .NUM_IRQ(64), .LEGACY_REV(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd1), .wr_en(wr1), .addr(addr),
    .wdata(wdata), .cpu_id(1'b0), .rdata(rdata1), .err(err1));
  irq_dist_regs #(.NUM_CPU(1), .NUM_IRQ(64), .LEGACY_REV(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd2), .wr_en(wr2), .addr(addr),
    .wdata(wdata), .cpu_id(1'b0), .rdata(rdata2), .err(err2));

  // {op(1=wr,2=rd,0=idle), addr, wdata, cpu, expected rdata, expected err, tag}
  localparam int NV = 26;
  localparam logic [36:0] VEC [NV] = '{
    {2'd1, 12'h828, 8'hFF, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 irq 40 write
    {2'd2, 12'h828, 8'h00, 2'd0, 8'h0F, 1'b0, 4'd3},  // R3 masked to 4 cpus
    {2'd0, 12'h000, 8'h00, 2'd0, 8'h00, 1'b0, 4'd2},  // R2 idle reads zero
    {2'd1, 12'h805, 8'hFF, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 irq 5 forced 0
    {2'd2, 12'h805, 8'h00, 2'd1, 8'h00, 1'b0, 4'd3},  // R3
    {2'd1, 12'h81E, 8'h00, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 irq 30 forced all
    {2'd2, 12'h81E, 8'h00, 2'd2, 8'h04, 1'b0, 4'd4},  // R4 own bit cpu2
    {2'd2, 12'h81D, 8'h00, 2'd3, 8'h08, 1'b0, 4'd4},  // R4 own bit cpu3
    {2'd2, 12'h81F, 8'h00, 2'd0, 8'h01, 1'b0, 4'd4},  // R4 own bit cpu0
    {2'd2, 12'h820, 8'h00, 2'd0, 8'h00, 1'b0, 4'd9},  // R9 reset value
    {2'd1, 12'h840, 8'hFF, 2'd0, 8'h00, 1'b1, 4'd5},  // R5 irq 64 write
    {2'd0, 12'h000, 8'h00, 2'd0, 8'h00, 1'b0, 4'd2},  // R2 err is one pulse
    {2'd2, 12'h840, 8'h00, 2'd0, 8'h00, 1'b1, 4'd5},  // R5 irq 64 read
    {2'd2, 12'h83F, 8'h00, 2'd0, 8'h00, 1'b0, 4'd5},  // R5 write above left no trace
    {2'd1, 12'h83F, 8'h35, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 irq 63
    {2'd2, 12'h83F, 8'h00, 2'd0, 8'h05, 1'b0, 4'd3},  // R3
    {2'd1, 12'h405, 8'hA0, 2'd1, 8'h00, 1'b0, 4'd8},  // R8 banked cpu1
    {2'd2, 12'h405, 8'h00, 2'd1, 8'hA0, 1'b0, 4'd8},  // R8
    {2'd2, 12'h405, 8'h00, 2'd2, 8'h00, 1'b0, 4'd8},  // R8 other cpu copy
    {2'd1, 12'h430, 8'h5C, 2'd3, 8'h00, 1'b0, 4'd8},  // R8 shared irq 48
    {2'd2, 12'h430, 8'h00, 2'd0, 8'h5C, 1'b0, 4'd8},  // R8
    {2'd2, 12'h440, 8'h00, 2'd0, 8'h00, 1'b1, 4'd5},  // R5 priority beyond
    {2'd1, 12'hC28, 8'hFF, 2'd0, 8'h00, 1'b0, 4'd1},  // R1 outside window
    {2'd1, 12'h028, 8'hFF, 2'd0, 8'h00, 1'b0, 4'd1},  // R1 outside window
    {2'd2, 12'h828, 8'h00, 2'd0, 8'h0F, 1'b0, 4'd1},  // R1 irq 40 untouched
    {2'd2, 12'hC05, 8'h00, 2'd0, 8'h00, 1'b0, 4'd1}   // R1 reads zero
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp,
                       input logic gerr, input logic eerr);
    n_cmp++;
    if (got !== exp || gerr !== eerr) begin
      n_bad++;
      $display("FAIL %s rdata=%h expected %h err=%b expected %b", tag, got, exp, gerr, eerr);
    end
  endtask

  task automatic acc(input int inst, input bit w, input bit r, input logic [11:0] a,
                     input logic [7:0] d, input logic [1:0] c, input logic [7:0] exp,
                     input logic eerr, input string tag);
    @(negedge clk);
    addr = a; wdata = d; cpu = c;
    rd0 = (inst == 0) && r; wr0 = (inst == 0) && w;
    rd1 = (inst == 1) && r; wr1 = (inst == 1) && w;
    rd2 = (inst == 2) && r; wr2 = (inst == 2) && w;
    @(negedge clk);
    rd0 = 0; wr0 = 0; rd1 = 0; wr1 = 0; rd2 = 0; wr2 = 0;
    case (inst)
      0:       check(tag, rdata0, exp, err0, eerr);
      1:       check(tag, rdata1, exp, err1, eerr);
      default: check(tag, rdata2, exp, err2, eerr);
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset outputs", rdata0, 8'h00, err0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      acc(0, v[36:35] == 2'd1, v[36:35] == 2'd2, v[34:23], v[22:15], v[14:13],
          v[12:5], v[4], $sformatf("R%0d vec%0d", v[3:0], i));
    end
    // R6 plain single-cpu build: routing window read-zero, write-ignore
    acc(1, 0, 1, 12'h828, 8'h00, 2'd0, 8'h00, 1'b0, "R6 read zero");
    acc(1, 1, 0, 12'h828, 8'hFF, 2'd0, 8'h00, 1'b0, "R6 write");
    acc(1, 0, 1, 12'h828, 8'h00, 2'd0, 8'h00, 1'b0, "R6 still zero");
    acc(1, 0, 1, 12'h900, 8'h00, 2'd0, 8'h00, 1'b0, "R6 no error beyond");
    acc(1, 1, 0, 12'h428, 8'h77, 2'd0, 8'h00, 1'b0, "R8 single-cpu prio write");
    acc(1, 0, 1, 12'h428, 8'h00, 2'd0, 8'h77, 1'b0, "R8 single-cpu prio read");
    // R7 legacy single-cpu build
    acc(2, 0, 1, 12'h828, 8'h00, 2'd0, 8'h01, 1'b0, "R7 reset target one");
    acc(2, 1, 0, 12'h828, 8'hFE, 2'd0, 8'h00, 1'b0, "R7 write masked");
    acc(2, 0, 1, 12'h828, 8'h00, 2'd0, 8'h00, 1'b0, "R7 masked to zero");
    acc(2, 0, 1, 12'h81E, 8'h00, 2'd0, 8'h01, 1'b0, "R7 fixed own bit");
    acc(2, 0, 1, 12'h840, 8'h00, 2'd0, 8'h00, 1'b1, "R7 bad register");
    // R9 reset restores defaults
    do_reset();
    acc(0, 0, 1, 12'h828, 8'h00, 2'd0, 8'h00, 1'b0, "R9 target cleared");
    acc(0, 0, 1, 12'h405, 8'h00, 2'd1, 8'h00, 1'b0, "R9 banked prio cleared");
    acc(0, 0, 1, 12'h430, 8'h00, 2'd0, 8'h00, 1'b0, "R9 shared prio cleared");
    acc(2, 0, 1, 12'h828, 8'h00, 2'd0, 8'h01, 1'b0, "R9 single-cpu target one");
    acc(1, 0, 1, 12'h428, 8'h00, 2'd0, 8'h00, 1'b0, "R9 single-cpu prio cleared");
    done = 1;
    summary();
    $finish;
  end
endmodule